// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM of 512K bytes. The requester offers one single-byte read or write at a time over a valid/ready handshake. The block turns each command into a timed sequence of active-low chip-select, write-strobe and output-gate signals, plus a registered address and write data. It returns read bytes on a one-cycle response pulse.

Every timing window is a whole number of clock cycles, and each count is a parameter. The defaults assume a 10 ns clock. A read keeps the output gate low for a wait window before it samples the bus. After a read, a turnaround gap lets the memory's drivers fall off the bus before the next command. A write is split into setup, strobe and hold phases so that the write strobe rises while address, data and chip-select are still held. Between commands the memory sits deselected and the block's own data driver is off.

Top module: `xsram_ctrl`

## Requirements
- R1: Out of reset, and in every cycle with no command in progress, the strobes are deselected: `mem_ce_n`=1, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=1. The block returns to this state for at least one cycle after every command.
- R2: A read accepted at a clock edge drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with the request address on `mem_addr`, for exactly RD_WAIT cycles starting at that edge.
- R3: The byte present on `mem_dq_in` at the last edge of the read window appears on `rsp_rdata`, with `rsp_valid` high for exactly one cycle, starting at that edge.
- R4: After a read window, the block spends TURN_CYC cycles with every strobe deselected, `mem_dq_oe`=0 and `req_ready`=0. Only after that can it accept another command.
- R5: A write accepted at an edge runs three phases in order, each with `mem_ce_n`=0 and `mem_dq_oe`=1: WR_SETUP cycles with `mem_we_n`=1, then WR_PULSE cycles with `mem_we_n`=0, then WR_HOLD cycles with `mem_we_n`=1. After that it returns to standby.
- R6: `mem_oe_n` stays high in every cycle of a write, so the write strobe and the output gate are never low together.
- R7: Through every cycle of a write, `mem_addr` and `mem_dq_out` hold the request's address and data. The byte held in the memory when the write strobe rises is therefore the requested byte.
- R8: `mem_dq_oe` is never high in a cycle in which the memory drives the bus (`mem_ce_n`=0, `mem_we_n`=1, `mem_oe_n`=0), nor in the cycle straight after one.
- R9: `req_ready` is low from the edge that accepts a command until the command, including any turnaround, has finished. A request raised and dropped during that time is never taken and leaves no trace in the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Address to memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_dq_out | output | 8 | Data toward the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Data from the pad |

## Verification
Two events can fall on the same cycle. One is a read's response pulse with its chip-select release. The other is a write request that the requester has kept raised since the read was accepted. The bench provokes this by switching the held request to a write straight after the read is taken. It then checks that the read byte still comes back intact. It also checks that the data driver stays off through the read window and the whole turnaround, and first turns on exactly one cycle after the standby cycle that accepts the write.

// File: rtl/xsram_pkg.sv
package xsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TURN = 3'd2,
    ST_WSET = 3'd3,
    ST_WPUL = 3'd4,
    ST_WHLD = 3'd5
  } xs_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ctr_width(input int maxc);
    return (maxc > 1) ? $clog2(maxc) : 1;
  endfunction

endpackage

// File: rtl/xsram_phase_ctr.sv
module xsram_phase_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/xsram_seq.sv
module xsram_seq
  import xsram_pkg::*;
#(
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 1,
  parameter int WR_HOLD  = 1,
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam int MAXC = max2(max2(RD_WAIT, TURN_CYC), max2(max2(WR_SETUP, WR_PULSE), WR_HOLD));
  localparam int CW   = ctr_width(MAXC);
  localparam logic [CW-1:0] LD_RD   = CW'(RD_WAIT - 1);
  localparam logic [CW-1:0] LD_TURN = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] LD_WSET = CW'(WR_SETUP - 1);
  localparam logic [CW-1:0] LD_WPUL = CW'(WR_PULSE - 1);
  localparam logic [CW-1:0] LD_WHLD = CW'(WR_HOLD - 1);

  xs_state_e     state_q, state_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          ph_last;
  logic          ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  xsram_phase_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .last     (ph_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  // next-state and phase-length selection
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (req_we) begin state_d = ST_WSET; ld_val = LD_WSET; end
        else        begin state_d = ST_RD;   ld_val = LD_RD;   end
      end
      ST_RD: if (ph_last) begin
        state_d = ST_TURN; ld = 1'b1; ld_val = LD_TURN; capture = 1'b1;
      end
      ST_TURN: if (ph_last) state_d = ST_IDLE;
      ST_WSET: if (ph_last) begin
        state_d = ST_WPUL; ld = 1'b1; ld_val = LD_WPUL;
      end
      ST_WPUL: if (ph_last) begin
        state_d = ST_WHLD; ld = 1'b1; ld_val = LD_WHLD;
      end
      ST_WHLD: if (ph_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobe levels decoded from the next state, then registered
  always_comb begin
    ce_n_d  = !(state_d inside {ST_RD, ST_WSET, ST_WPUL, ST_WHLD});
    oe_n_d  = (state_d != ST_RD);
    we_n_d  = (state_d != ST_WPUL);
    dq_oe_d = (state_d inside {ST_WSET, ST_WPUL, ST_WHLD});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_n_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

endmodule

// File: rtl/xsram_dpath.sv
module xsram_dpath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdat_d, rdat_d;

  always_comb begin
    addr_d = accept  ? req_addr  : mem_addr;
    wdat_d = accept  ? req_wdata : mem_dq_out;
    rdat_d = capture ? mem_dq_in : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      mem_addr   <= addr_d;
      mem_dq_out <= wdat_d;
      rsp_rdata  <= rdat_d;
      rsp_valid  <= capture;
    end
  end

endmodule

// File: rtl/xsram_ctrl.sv
module xsram_ctrl #(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 1,
  parameter int WR_HOLD  = 1,
  parameter int TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  logic accept, capture;

  xsram_seq #(
    .RD_WAIT  (RD_WAIT),
    .WR_SETUP (WR_SETUP),
    .WR_PULSE (WR_PULSE),
    .WR_HOLD  (WR_HOLD),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  xsram_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  logic mem_drv;
  assign mem_drv = !mem_ce_n && mem_we_n && !mem_oe_n;

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
  AST_GATE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_drv) |-> !mem_dq_oe); // R4
  AST_STROBE_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe)); // R5
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R7
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R7
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drv |-> !mem_dq_oe); // R8
  AST_BUSY_NO_SELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(req_ready) && !$past(req_valid)) |-> 1'b0); // R9

endmodule

// File: tb/sim_xsram_ctrl.sv
module sim_xsram_ctrl;

  localparam int RDW = 2;
  localparam int WS  = 1;
  localparam int WP  = 1;
  localparam int WH  = 1;
  localparam int TC  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xsram_ctrl #(
    .RD_WAIT(RDW), .WR_SETUP(WS), .WR_PULSE(WP), .WR_HOLD(WH), .TURN_CYC(TC)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model: drives on read strobes, latches on write strobe rise
  logic [7:0] mem_model [logic [18:0]];
  logic mem_drv;
  assign mem_drv = !mem_ce_n && mem_we_n && !mem_oe_n;

  always @* begin
    if (mem_drv)
      mem_dq_in = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h5C;
    else
      mem_dq_in = 8'hEE;
  end

  int we_falls = 0;
  always @(posedge mem_we_n) if (rst_n && !mem_ce_n) mem_model[mem_addr] = mem_dq_out;
  always @(negedge mem_we_n) if (rst_n) we_falls++;

  int contend = 0;
  int weoe    = 0;
  logic prev_drv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && (mem_drv || prev_drv)) contend++;
      if (!mem_we_n && !mem_oe_n) weoe++;
      prev_drv = mem_drv;
    end
  end

  function automatic logic [3:0] strobes();
    return {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1: reset and idle state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", {28'd0, strobes()}, 4'b1110);
    chk("R1", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {28'd0, strobes()}, 4'b1110);
    chk("R1", req_ready, 1);
  endtask

  // R2 R3 R4: read window, capture, turnaround
  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    chk("R9", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wdata = 8'h00;
    @(negedge clk); req_valid = 1'b0;
    for (int k = 1; k <= RDW; k++) begin
      chk("R2", {28'd0, strobes()}, 4'b0100);
      chk("R2", mem_addr, a);
      chk("R9", req_ready, 0);
      @(negedge clk);
    end
    chk("R3", rsp_valid, 1);
    chk("R3", rsp_rdata, exp);
    for (int k = 1; k <= TC; k++) begin
      chk("R4", {28'd0, strobes()}, 4'b1110);
      chk("R4", req_ready, 0);
      @(negedge clk);
    end
    chk("R3", rsp_valid, 0);
    chk("R1", req_ready, 1);
    chk("R1", {28'd0, strobes()}, 4'b1110);
  endtask

  // R5 R6 R7: write phases and stored byte
  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    chk("R9", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
    for (int k = 1; k <= WS; k++) begin
      chk("R5", {28'd0, strobes()}, 4'b0111);
      chk("R7", {5'd0, mem_addr, mem_dq_out}, {5'd0, a, d});
      @(negedge clk);
    end
    for (int k = 1; k <= WP; k++) begin
      chk("R6", {28'd0, strobes()}, 4'b0011);
      chk("R7", {5'd0, mem_addr, mem_dq_out}, {5'd0, a, d});
      @(negedge clk);
    end
    for (int k = 1; k <= WH; k++) begin
      chk("R5", {28'd0, strobes()}, 4'b0111);
      chk("R7", {5'd0, mem_addr, mem_dq_out}, {5'd0, a, d});
      @(negedge clk);
    end
    chk("R1", {28'd0, strobes()}, 4'b1110);
    chk("R7", mem_model.exists(a) ? mem_model[a] : 8'hxx, d);
  endtask

  // R4 R8: write request held through a read, same cycle as the response
  task automatic t_read_then_held_write(input logic [18:0] ra, input logic [7:0] rexp,
                                        input logic [18:0] wa, input logic [7:0] wd);
    req_valid = 1'b1; req_we = 1'b0; req_addr = ra;
    @(negedge clk);
    req_we = 1'b1; req_addr = wa; req_wdata = wd;
    for (int k = 1; k <= RDW + TC; k++) begin
      chk("R8", mem_dq_oe, 0);
      if (k == RDW + 1) begin
        chk("R3", rsp_valid, 1);
        chk("R3", rsp_rdata, rexp);
      end
      @(negedge clk);
    end
    chk("R4", req_ready, 1);
    chk("R4", mem_dq_oe, 0);
    @(negedge clk); req_valid = 1'b0;
    chk("R4", {28'd0, strobes()}, 4'b0111);
    repeat (WS + WP + WH) @(negedge clk);
    chk("R5", mem_model.exists(wa) ? mem_model[wa] : 8'hxx, wd);
    chk("R1", req_ready, 1);
  endtask

  // R9: request pulsed while busy is dropped
  task automatic t_busy_ignored(input logic [18:0] ra, input logic [7:0] rexp,
                                input logic [18:0] va, input logic [7:0] vold);
    int falls0;
    falls0 = we_falls;
    req_valid = 1'b1; req_we = 1'b0; req_addr = ra;
    @(negedge clk);
    req_we = 1'b1; req_addr = va; req_wdata = 8'h99;
    @(negedge clk);
    chk("R9", req_ready, 0);
    req_valid = 1'b0;
    repeat (RDW + TC - 1) @(negedge clk);
    chk("R9", req_ready, 1);
    chk("R9", we_falls, falls0);
    @(negedge clk);
    chk("R9", {28'd0, strobes()}, 4'b1110);
    do_read(va, vold);
    do_read(ra, rexp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    do_write(19'h12345, 8'hA5);
    do_read (19'h12345, 8'hA5);
    do_write(19'h00000, 8'h00);
    do_write(19'h7FFFF, 8'hFF);
    do_read (19'h7FFFF, 8'hFF);
    do_read (19'h00000, 8'h00);
    do_read (19'h00777, 8'h5C);
    do_write(19'h12345, 8'h3C);
    do_read (19'h12345, 8'h3C);
    t_read_then_held_write(19'h7FFFF, 8'hFF, 19'h2AAAA, 8'h5A);
    do_read (19'h2AAAA, 8'h5A);
    t_busy_ignored(19'h00000, 8'h00, 19'h12345, 8'h3C);
    repeat (3) @(negedge clk);
    chk("R8", contend, 0);
    chk("R6", weoe, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule